// File: doc/BRIEF.md
# Serial SAR ADC Read Controller

This block sits on the host side of a serial successive-approximation converter. The converter uses three wires: an active-low select, a serial clock and one data return line. When the block gets a start request while idle, it drives select low, which starts a conversion. The serial clock stays low while the conversion runs. The block passes the data line through a synchronizer and waits for the line to rise, which marks the end of the conversion. A timeout counter ends the wait early if that rise never comes.

After the rise, the block produces a divided serial clock and samples one bit on each falling edge, at the end of the high phase. The first sample is the marker bit and is thrown away. The next ten samples are the result, MSB first. In the long frame two further sub-bits are clocked out and dropped. At the last edge, select goes high and the result is presented with a one-cycle valid strobe. Busy then stays high for a programmable guard time, so that the converter can reacquire its input before the next select falls.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is asserted, select is high, the serial clock is low, and busy, valid, error and the result are all zero.
- R2: A start seen while busy is low drives select low on the next clock and raises busy. A start seen while busy is high has no effect, so each transaction has exactly one select falling edge.
- R3: The serial clock stays low from the select falling edge until a rising edge of the data line is detected through a two-stage synchronizer.
- R4: Each serial clock phase lasts div_i+1 system clocks. The first phase after detection is low, and the clock is low whenever select is high.
- R5: A frame has 11 falling edges when sub_mode_i is 0 and 13 when it is 1. The data line is sampled on the system clock where each falling edge occurs.
- R6: The first sample (the marker) is dropped, and the next 10 samples form result_o with the MSB first. The two trailing samples of a 13-edge frame are dropped.
- R7: On the last falling edge, select rises and valid_o pulses high for exactly one clock, with result_o updated on that same clock.
- R8: Busy stays high for guard_i+1 clocks after select rises, and then clears.
- R9: If no data-line rise is detected within timeout_i+1 clocks of the conversion wait, eoc_err_o is set and select rises. No serial clock edge and no valid strobe occur, and the guard time still applies. eoc_err_o clears when the next start is accepted.
- R10: sub_mode_i, div_i, timeout_i and guard_i are captured when a start is accepted. Changing them during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction request |
| sub_mode_i | input | 1 | 0: 11-edge frame, 1: 13-edge frame |
| div_i | input | DIV_W | Serial clock phase length minus one, in system clocks |
| timeout_i | input | TO_W | Conversion wait limit minus one, in system clocks |
| guard_i | input | GRD_W | Guard time minus one after select rises |
| adc_dout_i | input | 1 | Converter data line |
| adc_csn_o | output | 1 | Converter select, active low |
| adc_sclk_o | output | 1 | Converter serial clock |
| result_o | output | DATA_W | Last result |
| valid_o | output | 1 | One-clock strobe marking a new result |
| busy_o | output | 1 | Transaction or guard time in progress |
| eoc_err_o | output | 1 | Conversion-end timeout flag |

## Verification
The bench drives frames in both frame lengths. It uses several divider settings, conversion lengths and guard values, with data words of all zeros, all ones, alternating bits and a single set bit, so that any bit-order, off-by-one-edge or sub-bit leakage shows up in the result. A transaction whose conversion never ends separates the timeout path from the normal path, and the transaction after it shows that the error flag clears. One transaction repeats the start request and changes every configuration input partway through, which separates latched configuration from live inputs. An edge-by-edge converter model in the bench drives the data line, and a cycle-level reference compares every output on every clock.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GUARD = 2'd3
  } rd_state_e;
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  // line idles high while deselected, so reset to 1 avoids a false rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int DIV_W = 8,
  parameter int EC_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EC_W-1:0]  n_edges_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             last_o
);
  logic [DIV_W-1:0] hc_q;
  logic [EC_W-1:0]  ec_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap = (hc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      ec_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      hc_q   <= '0;
      ec_q   <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      hc_q   <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) ec_q <= ec_q + EC_W'(1);
    end else begin
      hc_q <= hc_q + DIV_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = run_i & wrap & sclk_q;
  assign last_o = fall_o & (ec_q == n_edges_i - EC_W'(1));
endmodule

// File: rtl/sar_frame_shift.sv
module sar_frame_shift #(
  parameter int DATA_W   = 10,
  parameter int SUB_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              sub_mode_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int SH_W = DATA_W + SUB_BITS;

  logic [SH_W-2:0] sh_q;
  logic [SH_W-1:0] nxt;

  assign nxt = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (shift_en_i) sh_q <= nxt[SH_W-2:0];
  end

  // result as it stands including the bit taken this cycle
  assign data_o = sub_mode_i ? nxt[SH_W-1:SUB_BITS] : nxt[DATA_W-1:0];
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SUB_BITS = 2,
  parameter int DIV_W    = 8,
  parameter int TO_W     = 16,
  parameter int GRD_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [GRD_W-1:0]  guard_i,
  input  logic              adc_dout_i,
  output logic              adc_csn_o,
  output logic              adc_sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              eoc_err_o
);
  localparam int FR_LONG  = DATA_W + SUB_BITS + 1;
  localparam int FR_SHORT = DATA_W + 1;
  localparam int EC_W     = $clog2(FR_LONG + 1);
  localparam int CNT_W    = (TO_W > GRD_W) ? TO_W : GRD_W;

  rd_state_e         st_q;
  logic              csn_q, valid_q, err_q, sub_q;
  logic [DATA_W-1:0] result_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  div_q;
  logic [TO_W-1:0]   to_q;
  logic [GRD_W-1:0]  grd_q;

  logic              dout_lvl, dout_rise;
  logic              bit_fall, frame_last;
  logic [DATA_W-1:0] frame_data;
  logic [EC_W-1:0]   n_edges;
  logic              shift_run;

  assign n_edges   = sub_q ? EC_W'(FR_LONG) : EC_W'(FR_SHORT);
  assign shift_run = (st_q == ST_SHIFT);

  sar_in_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (adc_dout_i),
    .lvl_o  (dout_lvl),
    .rise_o (dout_rise)
  );

  sar_sclk_gen #(.DIV_W(DIV_W), .EC_W(EC_W)) u_sclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (shift_run),
    .div_i     (div_q),
    .n_edges_i (n_edges),
    .sclk_o    (adc_sclk_o),
    .fall_o    (bit_fall),
    .last_o    (frame_last)
  );

  sar_frame_shift #(.DATA_W(DATA_W), .SUB_BITS(SUB_BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (bit_fall),
    .bit_i      (dout_lvl),
    .sub_mode_i (sub_q),
    .data_o     (frame_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      csn_q    <= 1'b1;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
      cnt_q    <= '0;
      sub_q    <= 1'b0;
      div_q    <= '0;
      to_q     <= '0;
      grd_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_CONV;
            csn_q <= 1'b0;
            err_q <= 1'b0;
            cnt_q <= '0;
            sub_q <= sub_mode_i;
            div_q <= div_i;
            to_q  <= timeout_i;
            grd_q <= guard_i;
          end
        end
        ST_CONV: begin
          if (dout_rise) begin
            st_q <= ST_SHIFT;
          end else if (cnt_q == CNT_W'(to_q)) begin
            st_q  <= ST_GUARD;
            csn_q <= 1'b1;
            err_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (frame_last) begin
            st_q     <= ST_GUARD;
            csn_q    <= 1'b1;
            valid_q  <= 1'b1;
            result_q <= frame_data;
            cnt_q    <= '0;
          end
        end
        ST_GUARD: begin
          if (cnt_q == CNT_W'(grd_q)) st_q <= ST_IDLE;
          else                        cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_csn_o = csn_q;
  assign result_o  = result_q;
  assign valid_o   = valid_q;
  assign eoc_err_o = err_q;
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic adc_csn_o,
  input logic adc_sclk_o,
  input logic valid_o,
  input logic busy_o,
  input logic eoc_err_o
);
  p_sclk_low_deselected_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_csn_o |-> !adc_sclk_o);

  p_start_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!adc_csn_o && busy_o));

  p_valid_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_ends_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(adc_csn_o));

  p_select_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_csn_o |-> busy_o);

  p_guard_no_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && adc_csn_o) |=> adc_csn_o);

  p_timeout_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_err_o) |-> ($rose(adc_csn_o) && !valid_o));
endmodule

bind sar_adc_reader sar_adc_reader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .adc_csn_o  (adc_csn_o),
  .adc_sclk_o (adc_sclk_o),
  .valid_o    (valid_o),
  .busy_o     (busy_o),
  .eoc_err_o  (eoc_err_o)
);

// File: tb/tb_sar_adc_reader.sv
module tb_sar_adc_reader;
  localparam int DATA_W = 10, SUB_BITS = 2, DIV_W = 8, TO_W = 16, GRD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              start_i = 1'b0;
  logic              sub_mode_i = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic [TO_W-1:0]   timeout_i = '0;
  logic [GRD_W-1:0]  guard_i = '0;
  logic              adc_dout = 1'b1;
  logic              adc_csn_o, adc_sclk_o, valid_o, busy_o, eoc_err_o;
  logic [DATA_W-1:0] result_o;

  sar_adc_reader #(.DATA_W(DATA_W), .SUB_BITS(SUB_BITS), .DIV_W(DIV_W),
                   .TO_W(TO_W), .GRD_W(GRD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .sub_mode_i(sub_mode_i),
    .div_i(div_i), .timeout_i(timeout_i), .guard_i(guard_i),
    .adc_dout_i(adc_dout), .adc_csn_o(adc_csn_o), .adc_sclk_o(adc_sclk_o),
    .result_o(result_o), .valid_o(valid_o), .busy_o(busy_o), .eoc_err_o(eoc_err_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // reference model: behavioural, updated once per rising clock
  int m_mode, m_cnt, m_hc, m_ec, m_sh, m_res, m_div, m_to, m_grd, m_frame;
  bit m_csn, m_sclk, m_valid, m_err, m_sub, m_s1, m_s2, m_s3, m_rise, m_bit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_hc = 0; m_ec = 0; m_sh = 0; m_res = 0;
      m_div = 0; m_to = 0; m_grd = 0; m_sub = 0;
      m_csn = 1; m_sclk = 0; m_valid = 0; m_err = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1;
    end else begin
      m_rise = m_s2 && !m_s3;
      m_bit  = m_s2;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = adc_dout;
      m_valid = 0;
      case (m_mode)
        0: if (start_i) begin
             m_mode = 1; m_csn = 0; m_err = 0; m_cnt = 0;
             m_sub = sub_mode_i; m_div = div_i; m_to = timeout_i; m_grd = guard_i;
           end
        1: if (m_rise) begin
             m_mode = 2; m_hc = 0; m_ec = 0; m_sclk = 0;
           end else if (m_cnt == m_to) begin
             m_mode = 3; m_csn = 1; m_err = 1; m_cnt = 0;
           end else m_cnt++;
        2: begin
             m_frame = m_sub ? DATA_W + SUB_BITS + 1 : DATA_W + 1;
             if (m_hc == m_div) begin
               m_hc = 0;
               if (m_sclk) begin
                 m_sclk = 0;
                 m_sh = ((m_sh << 1) | int'(m_bit)) & 32'h1fff;
                 m_ec++;
                 if (m_ec == m_frame) begin
                   m_res = m_sub ? ((m_sh >> SUB_BITS) & 32'h3ff) : (m_sh & 32'h3ff);
                   m_valid = 1; m_csn = 1; m_mode = 3; m_cnt = 0;
                 end
               end else m_sclk = 1;
             end else m_hc++;
           end
        default: if (m_cnt == m_grd) m_mode = 0; else m_cnt++;
      endcase
    end
  end

  // converter model and per-clock compare, both on the falling clock
  int  a_data, a_sub, a_conv, a_cd, a_p;
  bit  a_done = 0, a_prev_csn = 1, a_prev_sclk = 0;
  int  f_falls, f_csn_falls, f_guard, f_valid, f_res;

  function automatic bit frame_bit(input int p);
    if (p >= 1 && p <= DATA_W) return bit'((a_data >> (DATA_W - p)) & 1);
    if (p > DATA_W && p <= DATA_W + SUB_BITS) return bit'((a_sub >> (DATA_W + SUB_BITS - p)) & 1);
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(adc_csn_o == m_csn, "R2 select", adc_csn_o, m_csn);
      chk(adc_sclk_o == m_sclk, "R4 serial clock", adc_sclk_o, m_sclk);
      chk(valid_o == m_valid, "R7 valid", valid_o, m_valid);
      chk(int'(result_o) == m_res, "R6 result", result_o, m_res);
      chk(busy_o == (m_mode != 0), "R8 busy", busy_o, m_mode != 0);
      chk(eoc_err_o == m_err, "R9 error", eoc_err_o, m_err);
      if (!adc_csn_o && !a_done)
        chk(!adc_sclk_o, "R3 clock low in conversion", adc_sclk_o, 0);
      if (a_prev_sclk && !adc_sclk_o) f_falls++;
      if (a_prev_csn && !adc_csn_o) f_csn_falls++;
      if (adc_csn_o && busy_o) f_guard++;
      if (valid_o) begin f_valid++; f_res = int'(result_o); end

      if (adc_csn_o) begin
        adc_dout = 1; a_done = 0;
      end else if (a_prev_csn) begin
        adc_dout = 0; a_cd = a_conv; a_done = 0;
      end else if (!a_done) begin
        if (a_cd == 0) begin adc_dout = 1; a_done = 1; a_p = 0; end
        else if (a_cd > 0) a_cd--;
      end else if (a_prev_sclk && !adc_sclk_o) begin
        a_p++;
        adc_dout = frame_bit(a_p);
      end
      a_prev_csn  = adc_csn_o;
      a_prev_sclk = adc_sclk_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R2 watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic run_frame(input bit sub, input int div, input int data, input int subbits,
                           input int conv, input int grd, input int to, input int poke);
    int exp_falls;
    a_data = data; a_sub = subbits; a_conv = conv;
    f_falls = 0; f_csn_falls = 0; f_guard = 0; f_valid = 0; f_res = -1;
    @(negedge clk);
    sub_mode_i = sub; div_i = DIV_W'(div); guard_i = GRD_W'(grd); timeout_i = TO_W'(to);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(eoc_err_o == 0, "R9 error cleared on start", eoc_err_o, 0);
    chk(busy_o == 1 && adc_csn_o == 0, "R2 start accepted", {busy_o, adc_csn_o}, 2);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start_i = 1; sub_mode_i = !sub; div_i = DIV_W'(div + 3);
      guard_i = GRD_W'(grd + 7); timeout_i = TO_W'(2);
      @(negedge clk);
      start_i = 0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    exp_falls = (conv < 0) ? 0 : (sub ? DATA_W + SUB_BITS + 1 : DATA_W + 1);
    chk(f_falls == exp_falls, "R5 falling edges per frame", f_falls, exp_falls);
    chk(f_csn_falls == 1, "R2 one select fall per transaction", f_csn_falls, 1);
    chk(f_guard == grd + 1, "R8 guard length", f_guard, grd + 1);
    if (conv < 0) begin
      chk(f_valid == 0, "R9 no valid on timeout", f_valid, 0);
      chk(eoc_err_o == 1, "R9 timeout flag", eoc_err_o, 1);
    end else begin
      chk(f_valid == 1, "R7 one valid strobe", f_valid, 1);
      chk(f_res == data, "R6 result word", f_res, data);
      if (poke > 0) chk(f_res == data, "R10 config latched", f_res, data);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_csn_o == 1, "R1 reset select", adc_csn_o, 1);
    chk(adc_sclk_o == 0, "R1 reset clock", adc_sclk_o, 0);
    chk({busy_o, valid_o, eoc_err_o} == 3'b000, "R1 reset flags", {busy_o, valid_o, eoc_err_o}, 0);
    chk(result_o == 0, "R1 reset result", result_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_frame(0, 1, 10'h2a5, 3, 20, 5, 200, 0);
    run_frame(1, 3, 10'h3ff, 2, 8, 0, 200, 0);
    run_frame(0, 2, 10'h000, 3, 40, 10, 200, 0);
    run_frame(1, 1, 10'h155, 1, 15, 3, 200, 30);
    run_frame(0, 1, 10'h000, 0, -1, 4, 30, 0);
    run_frame(0, 4, 10'h200, 0, 5, 2, 100, 0);
    run_frame(1, 2, 10'h001, 3, 12, 1, 100, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule